// File: doc/BRIEF.md
# Windowed Carrier Activity Serializer

This block watches the carrier-sense lines of a nine-port repeater: one attachment-unit port and eight twisted-pair ports. It reports which ports were recently active on one serial pin that never stops. Time is cut into fixed windows of `WINDOW_CYCLES` clock cycles, 2 ms in the target system (40000 cycles at 20 MHz).

Inside a window, every port's carrier line is sampled on every clock. Any high sample, even a single cycle long, sets a sticky flag for that port. When a window closes, the flags are moved into a report word and cleared. The report word is then streamed out over and over, in step with the clock, for the whole of the following window. A brief burst of activity is therefore stretched into one full window of reported activity.

Each serial frame has `NUM_PORTS + 2` bits and frames follow each other with no gap. A frame starts with a high start bit. Next come the attachment-unit bit and then twisted-pair ports 0 through 7. A low stop bit ends the frame.

Top module: `car_activity_serializer`

## Requirements
- R1: While `rst_n` is low, `serial_o` is low and all flags and the report word are cleared. The first frames after release therefore carry all-zero port bits.
- R2: The report word changes only at window boundaries, which occur every `WINDOW_CYCLES` clocks counted from reset release. A carrier held high continuously reports that port as active in every window after the first.
- R3: A carrier pulse of one clock cycle on a port, anywhere in a window, sets that port's bit in the report for the entire following window.
- R4: The frame length is `NUM_PORTS + 2` bits and frames repeat back to back. Bit 0 of the frame is the start bit (1) and the last bit is the stop bit (0).
- R5: A port with no carrier during a window reports 0 for the whole next window, even if it was active in the window before.
- R6: A carrier sample taken in the last cycle of a window goes into the freshly cleared flag for the next window. It is reported in the window after that, and it is never dropped.
- R7: Frame bit 1 carries `carrier_i[0]` (the attachment-unit port). Frame bits 2 to 9 carry `carrier_i[1]` to `carrier_i[8]` (twisted-pair ports 0 to 7). Each `serial_o` bit is registered, so it appears one clock after the cycle that selects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; the serial stream runs at one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| carrier_i | input | NUM_PORTS | Carrier-sense lines; bit 0 is the attachment-unit port, bits 1 to 8 are twisted-pair ports 0 to 7 |
| serial_o | output | 1 | Continuous serial activity report |

## Verification
A one-cycle pulse is walked across each of the nine ports in turn, with one port per window. This checks bit order and proves that the shortest activity is stretched to a full window. A pulse placed in the last cycle of a window separates correct boundary handling from a design that loses the pulse or reports it one window early. Quiet windows that follow active ones show whether stale bits are cleared. A continuous all-ports carrier checks that the boundary period is exact. The window length is chosen coprime with the frame length, so every port bit position is checked against every phase of the window.

// File: rtl/car_pkg.sv
package car_pkg;

  // Phase of the serial frame currently being emitted.
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_DATA  = 2'd1,
    PH_STOP  = 2'd2
  } frame_phase_e;

  localparam logic START_LEVEL = 1'b1;
  localparam logic STOP_LEVEL  = 1'b0;

endpackage

// File: rtl/car_window_timer.sv
module car_window_timer #(
  parameter int WINDOW_CYCLES = 40000,
  parameter int CNT_W         = $clog2(WINDOW_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  output logic boundary_o
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  always_comb begin
    at_last = (cnt_q == LAST_CNT);
    if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign boundary_o = at_last;

  // Window position never leaves the legal range (window period, R2)
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT);

  // After a boundary the count restarts at zero (R2)
  assert_cnt_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_o |=> (cnt_q == '0));

endmodule

// File: rtl/car_activity_capture.sv
module car_activity_capture #(
  parameter int NUM_PORTS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boundary_i,
  input  logic [NUM_PORTS-1:0] carrier_i,
  output logic [NUM_PORTS-1:0] report_o
);

  logic [NUM_PORTS-1:0] flag_q;
  logic [NUM_PORTS-1:0] flag_d;
  logic [NUM_PORTS-1:0] report_q;
  logic [NUM_PORTS-1:0] report_d;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    // A boundary restarts the flag from the current sample, so a pulse in
    // the boundary cycle survives into the new window.
    always_comb begin
      if (boundary_i) begin
        flag_d[g]   = carrier_i[g];
        report_d[g] = flag_q[g];
      end else begin
        flag_d[g]   = flag_q[g] | carrier_i[g];
        report_d[g] = report_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g]   <= 1'b0;
        report_q[g] <= 1'b0;
      end else begin
        flag_q[g]   <= flag_d[g];
        report_q[g] <= report_d[g];
      end
    end
  end

  assign report_o = report_q;

  // Flags are sticky inside a window (R3)
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // Report moves only at a window boundary (R2)
  assert_report_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(report_q));

  // Boundary-cycle activity lands in the new window's flag (R6)
  assert_boundary_sample_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i |=> (flag_q == $past(carrier_i)));

endmodule

// File: rtl/car_frame_serializer.sv
module car_frame_serializer
  import car_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int FRAME_LEN = NUM_PORTS + 2,
  parameter int POS_W     = $clog2(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] report_i,
  output logic                 serial_o
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] data_idx;
  frame_phase_e     phase;
  logic             bit_d;
  logic             bit_q;

  always_comb begin
    if (pos_q == '0) begin
      phase = PH_START;
    end else if (pos_q == LAST_POS) begin
      phase = PH_STOP;
    end else begin
      phase = PH_DATA;
    end
  end

  always_comb begin
    data_idx = pos_q - POS_W'(1);
    pos_d    = (pos_q == LAST_POS) ? '0 : (pos_q + POS_W'(1));
    unique case (phase)
      PH_START: bit_d = START_LEVEL;
      PH_STOP:  bit_d = STOP_LEVEL;
      default:  bit_d = report_i[data_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      bit_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      bit_q <= bit_d;
    end
  end

  assign serial_o = bit_q;

  // Start bit is high (R4)
  assert_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0) |=> serial_o);

  // Stop bit is low (R4)
  assert_stop_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == LAST_POS) |=> !serial_o);

  // Frames follow back to back (R4)
  assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == LAST_POS) |=> (pos_q == '0));

endmodule

// File: rtl/car_activity_serializer.sv
module car_activity_serializer #(
  parameter int NUM_PORTS     = 9,
  parameter int WINDOW_CYCLES = 40000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] carrier_i,
  output logic                 serial_o
);

  localparam int CNT_W     = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam int FRAME_LEN = NUM_PORTS + 2;
  localparam int POS_W     = $clog2(FRAME_LEN);

  logic                 boundary;
  logic [NUM_PORTS-1:0] report;

  car_window_timer #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .CNT_W         (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_o (boundary)
  );

  car_activity_capture #(
    .NUM_PORTS (NUM_PORTS)
  ) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary),
    .carrier_i  (carrier_i),
    .report_o   (report)
  );

  car_frame_serializer #(
    .NUM_PORTS (NUM_PORTS),
    .FRAME_LEN (FRAME_LEN),
    .POS_W     (POS_W)
  ) u_serializer (
    .clk      (clk),
    .rst_n    (rst_n),
    .report_i (report),
    .serial_o (serial_o)
  );

  // Output held low during reset (R1)
  always_comb begin
    if (!rst_n) begin
      assert_low_in_reset_R1: assert (serial_o == 1'b0);
    end
  end

endmodule

// File: tb/car_activity_serializer_tb.sv
module car_activity_serializer_tb;

  localparam int N  = 9;
  localparam int W  = 23;
  localparam int F  = N + 2;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] carrier;
  logic         serial_o;

  int n_checks;
  int n_fail;

  // Reference state, derived from the requirements
  int           m_cnt;
  int           m_pos;
  logic [N-1:0] m_flag;
  logic [N-1:0] m_rep;

  car_activity_serializer #(
    .NUM_PORTS     (N),
    .WINDOW_CYCLES (W)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .carrier_i (carrier),
    .serial_o  (serial_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: serial_o=%b expected=%b (cnt=%0d pos=%0d)",
               tag, act, exp, m_cnt, m_pos);
    end
  endtask

  // One clock: drive at negedge, predict, compare at the next negedge.
  task automatic step(input logic [N-1:0] c, input string tag);
    logic  exp;
    string t;
    carrier = c;
    if (m_pos == 0) begin
      exp = 1'b1; t = "R4";
    end else if (m_pos == F - 1) begin
      exp = 1'b0; t = "R4";
    end else begin
      exp = m_rep[m_pos - 1]; t = tag;
    end
    if (m_cnt == W - 1) begin
      m_rep  = m_flag;
      m_flag = c;
      m_cnt  = 0;
    end else begin
      m_flag = m_flag | c;
      m_cnt  = m_cnt + 1;
    end
    m_pos = (m_pos == F - 1) ? 0 : m_pos + 1;
    @(posedge clk);
    @(negedge clk);
    check(serial_o, exp, t);
  endtask

  // One full window with a one-cycle pulse of mask at window offset off.
  task automatic run_window(input logic [N-1:0] mask, input int off, input string tag);
    for (int k = 0; k < W; k++) begin
      step((m_cnt == off) ? mask : '0, tag);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    carrier  = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(serial_o, 1'b0, "R1");
    rst_n  = 1'b1;
    carrier = '0;
    m_cnt  = 0;
    m_pos  = 0;
    m_flag = '0;
    m_rep  = '0;

    // R1: zero report after release
    run_window('0, 0, "R1");

    // R7 / R3: walk a single pulse across every port at varied offsets
    for (int p = 0; p < N; p++) begin
      run_window(N'(1) << p, (p * 5) % W, "R7");
    end
    run_window('0, 0, "R3");

    // R5: active window followed by quiet windows
    run_window(9'h155, 3, "R3");
    run_window('0, 0, "R5");
    run_window('0, 0, "R5");

    // R6: pulse in the last cycle of a window, per port group
    run_window(9'h0AA, W - 1, "R6");
    run_window('0, 0, "R6");
    run_window('0, 0, "R6");
    run_window(9'h101, W - 1, "R6");
    run_window(9'h0FE, 0, "R6");
    run_window('0, 0, "R6");

    // R2: continuous carrier on all ports, then removed
    for (int k = 0; k < 3 * W; k++) step('1, "R2");
    for (int k = 0; k < 2 * W; k++) step('0, "R2");

    // R1: reset mid-stream clears report and output
    @(negedge clk);
    carrier = '1;
    rst_n   = 1'b0;
    #1;
    check(serial_o, 1'b0, "R1");
    @(negedge clk);
    rst_n  = 1'b1;
    carrier = '0;
    m_cnt  = 0;
    m_pos  = 0;
    m_flag = '0;
    m_rep  = '0;
    run_window('0, 0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule